// File: doc/BRIEF.md
# Orientation-aware request scheduler for a dual-addressing bank group

This block schedules memory requests for a memory whose subarrays can be read either along a row or along a column. A single request queue serves a group of four adjacent banks. Each queued request carries its orientation (row or column), the bank within the group, the subarray within the bank, the row or column index, a write flag and a tag. For every subarray the scheduler tracks whether its row buffer, its column buffer or neither is open, and which index is open. From that state it issues precharge (close and write back), activate and read/write commands on one shared command/address path.

Selection runs in two levels. A read/write arbiter picks the oldest eligible request that hits an open buffer. An activation arbiter picks the oldest eligible request that misses and needs a precharge or an activate. The second level grants the shared path and always prefers the read/write candidate. A request is eligible only when no older queued request targets the same subarray, so all accesses to one subarray, of either orientation, are served strictly in arrival order. Separate subarrays of one bank keep their buffers open independently. Each command holds the path for a fixed number of cycles, and a read/write reports its tag on a completion pulse when its occupancy ends.

Top module: `osched_top`

## Requirements
- R1: After reset, cmd_valid and done_valid are low and req_ready is high.
- R2: req_ready is low exactly when DEPTH (default 16) requests are held, a request being held from its acceptance until its read/write command is issued.
- R3: Every command reports its target bank and subarray; cmd_kind encodes 1 = precharge, 2 = activate, 3 = read/write; cmd_orient is 0 for row and 1 for column. Activate and read/write carry the request's orientation and index; read/write also carries its write flag and tag; precharge carries the orientation and index of the buffer being closed.
- R4: A request to a subarray with no open buffer issues an activate with its orientation and index, then its read/write.
- R5: A request whose orientation and index both match the open buffer of its subarray issues only a read/write, with no activate.
- R6: A request that misses an open buffer (other orientation, or same orientation with another index) issues a precharge of the open buffer, then an activate, then its read/write; a row and a column buffer of one subarray are never open together.
- R7: Requests to the same subarray complete in arrival order, whatever their orientations.
- R8: Buffers opened in different subarrays of one bank stay open together, so later hits to each of them need no activate.
- R9: When a read/write and an activation or precharge are both ready to issue, the read/write is granted first.
- R10: Among requests waiting for activation on different subarrays, the oldest is served first.
- R11: After a precharge, activate or read/write, the next command issues no earlier than T_PRE, T_ACT or T_RW cycles later respectively (defaults 2, 3, 2), and exactly that many cycles later when work is waiting.
- R12: done_valid pulses for one cycle exactly T_RW cycles after a read/write command, with that command's tag on done_tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue has room; request accepted when both are high |
| req_orient | input | 1 | 0 = row access, 1 = column access |
| req_bank | input | BANK_W | Bank within the group |
| req_sub | input | SUB_W | Subarray within the bank |
| req_idx | input | IDX_W | Row or column index to open |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tag | input | TAG_W | Request tag returned on completion |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_kind | output | 2 | 1 precharge, 2 activate, 3 read/write |
| cmd_orient | output | 1 | Buffer orientation of the command |
| cmd_bank | output | BANK_W | Target bank |
| cmd_sub | output | SUB_W | Target subarray |
| cmd_idx | output | IDX_W | Row or column index |
| cmd_write | output | 1 | Write flag of a read/write |
| cmd_tag | output | TAG_W | Tag of the request behind the command |
| done_valid | output | 1 | Completion pulse |
| done_tag | output | TAG_W | Tag of the completed request |

## Verification
The assertions assume the request fields are stable whenever req_valid is high and that T_PRE, T_ACT and T_RW are all at least one; they also assume an issued precharge is only ever followed on that subarray by an activate, which the scheduler guarantees by its own ordering. The stimulus drives every request at the falling edge and holds it until the rising edge where req_ready is high, and keeps each scenario on subarrays whose buffer state is known from the earlier scenarios, so each expected command stream can be written down in advance. Path occupancy and completion timing are checked on every command the bench sees.

// File: rtl/osched_pkg.sv
package osched_pkg;

    typedef enum logic [1:0] {
        SA_IDLE = 2'd0,
        SA_ROW  = 2'd1,
        SA_COL  = 2'd2
    } sa_state_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_PRE  = 2'd1,
        CMD_ACT  = 2'd2,
        CMD_RW   = 2'd3
    } cmd_kind_e;

endpackage

// File: rtl/osched_queue.sv
module osched_queue #(
    parameter int DEPTH  = 16,
    parameter int BANK_W = 2,
    parameter int SUB_W  = 2,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic                          push_orient,
    input  logic [BANK_W-1:0]             push_bank,
    input  logic [SUB_W-1:0]              push_sub,
    input  logic [IDX_W-1:0]              push_idx,
    input  logic                          push_write,
    input  logic [TAG_W-1:0]              push_tag,
    input  logic                          pop,
    input  logic [$clog2(DEPTH)-1:0]      pop_sel,
    output logic [DEPTH-1:0]              q_valid,
    output logic [DEPTH-1:0]              q_orient,
    output logic [DEPTH-1:0][BANK_W-1:0]  q_bank,
    output logic [DEPTH-1:0][SUB_W-1:0]   q_sub,
    output logic [DEPTH-1:0][IDX_W-1:0]   q_idx,
    output logic [DEPTH-1:0]              q_write,
    output logic [DEPTH-1:0][TAG_W-1:0]   q_tag,
    output logic                          full
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int SEL_W = $clog2(DEPTH);

    typedef struct packed {
        logic              orient;
        logic [BANK_W-1:0] bank;
        logic [SUB_W-1:0]  sub;
        logic [IDX_W-1:0]  idx;
        logic              write;
        logic [TAG_W-1:0]  tag;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0]  ent;
        logic [CNT_W-1:0]  cnt;
    } qstate_t;

    qstate_t s_d, s_q;
    logic [CNT_W-1:0] cnt_after;

    // Oldest entry sits at slot 0; removal closes the gap so slot order is age order.
    always_comb begin
        s_d       = s_q;
        cnt_after = s_q.cnt - CNT_W'(pop);
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (i >= int'(pop_sel)) begin
                    s_d.ent[i] = s_q.ent[i+1];
                end
            end
            s_d.ent[DEPTH-1] = '0;
        end
        if (push) begin
            s_d.ent[cnt_after[SEL_W-1:0]] = '{orient: push_orient, bank: push_bank,
                                              sub: push_sub, idx: push_idx,
                                              write: push_write, tag: push_tag};
        end
        s_d.cnt = cnt_after + CNT_W'(push);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            q_valid[i]  = (CNT_W'(i) < s_q.cnt);
            q_orient[i] = s_q.ent[i].orient;
            q_bank[i]   = s_q.ent[i].bank;
            q_sub[i]    = s_q.ent[i].sub;
            q_idx[i]    = s_q.ent[i].idx;
            q_write[i]  = s_q.ent[i].write;
            q_tag[i]    = s_q.ent[i].tag;
        end
        full = (s_q.cnt == CNT_W'(DEPTH));
    end

    // R2: the edge never pushes into a queue that is already full
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (s_q.cnt < CNT_W'(DEPTH)));

    // R7: only a held entry can be removed
    p_pop_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (CNT_W'(pop_sel) < s_q.cnt));

endmodule

// File: rtl/osched_sa_table.sv
module osched_sa_table
    import osched_pkg::*;
#(
    parameter int SA_N  = 16,
    parameter int IDX_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         upd_en,
    input  logic [$clog2(SA_N)-1:0]      upd_addr,
    input  logic [1:0]                   upd_state,
    input  logic [IDX_W-1:0]             upd_idx,
    output logic [SA_N-1:0][1:0]         sa_st,
    output logic [SA_N-1:0][IDX_W-1:0]   sa_ix
);

    typedef struct packed {
        logic [SA_N-1:0][1:0]       st;
        logic [SA_N-1:0][IDX_W-1:0] ix;
    } tstate_t;

    tstate_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (upd_en) begin
            t_d.st[upd_addr] = upd_state;
            t_d.ix[upd_addr] = upd_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign sa_st = t_q.st;
    assign sa_ix = t_q.ix;

    // R4: a buffer is only opened in a subarray whose buffers are both closed
    p_open_from_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_state != SA_IDLE) |-> (t_q.st[upd_addr] == SA_IDLE));

    // R6: a precharge always closes a buffer that is open
    p_close_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_state == SA_IDLE) |-> (t_q.st[upd_addr] != SA_IDLE));

endmodule

// File: rtl/osched_pick.sv
module osched_pick
    import osched_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int BANK_W = 2,
    parameter int SUB_W  = 2,
    parameter int IDX_W  = 4
) (
    input  logic [DEPTH-1:0]                          q_valid,
    input  logic [DEPTH-1:0]                          q_orient,
    input  logic [DEPTH-1:0][BANK_W-1:0]              q_bank,
    input  logic [DEPTH-1:0][SUB_W-1:0]               q_sub,
    input  logic [DEPTH-1:0][IDX_W-1:0]               q_idx,
    input  logic [(1<<(BANK_W+SUB_W))-1:0][1:0]       sa_st,
    input  logic [(1<<(BANK_W+SUB_W))-1:0][IDX_W-1:0] sa_ix,
    output logic                                      rw_found,
    output logic [$clog2(DEPTH)-1:0]                  rw_sel,
    output logic                                      act_found,
    output logic [$clog2(DEPTH)-1:0]                  act_sel,
    output logic                                      act_pre
);

    localparam int ADDR_W = BANK_W + SUB_W;
    localparam int SEL_W  = $clog2(DEPTH);

    logic [DEPTH-1:0]             elig;
    logic [DEPTH-1:0]             hit;
    logic [DEPTH-1:0][ADDR_W-1:0] addr;
    logic [1:0]                   want;

    // An entry is eligible only when it is the oldest one for its subarray.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            addr[i] = {q_bank[i], q_sub[i]};
        end
        for (int i = 0; i < DEPTH; i++) begin
            elig[i] = q_valid[i];
            for (int j = 0; j < i; j++) begin
                if (q_valid[j] && addr[j] == addr[i]) begin
                    elig[i] = 1'b0;
                end
            end
            want   = q_orient[i] ? SA_COL : SA_ROW;
            hit[i] = (sa_st[addr[i]] == want) && (sa_ix[addr[i]] == q_idx[i]);
        end
    end

    // Level one: both arbiters take the oldest candidate of their class.
    always_comb begin
        rw_found  = 1'b0;
        rw_sel    = '0;
        act_found = 1'b0;
        act_sel   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!rw_found && elig[i] && hit[i]) begin
                rw_found = 1'b1;
                rw_sel   = SEL_W'(i);
            end
            if (!act_found && elig[i] && !hit[i]) begin
                act_found = 1'b1;
                act_sel   = SEL_W'(i);
            end
        end
        act_pre = (sa_st[addr[act_sel]] != SA_IDLE);
    end

endmodule

// File: rtl/osched_top.sv
module osched_top
    import osched_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int BANK_W = 2,
    parameter int SUB_W  = 2,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 4,
    parameter int T_PRE  = 2,
    parameter int T_ACT  = 3,
    parameter int T_RW   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_orient,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [SUB_W-1:0]  req_sub,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic              req_write,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic              cmd_orient,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [SUB_W-1:0]  cmd_sub,
    output logic [IDX_W-1:0]  cmd_idx,
    output logic              cmd_write,
    output logic [TAG_W-1:0]  cmd_tag,
    output logic              done_valid,
    output logic [TAG_W-1:0]  done_tag
);

    localparam int ADDR_W = BANK_W + SUB_W;
    localparam int SA_N   = 1 << ADDR_W;
    localparam int SEL_W  = $clog2(DEPTH);
    localparam int T_MAX  = (T_PRE > T_ACT) ? ((T_PRE > T_RW) ? T_PRE : T_RW)
                                            : ((T_ACT > T_RW) ? T_ACT : T_RW);
    localparam int BUSY_W = $clog2(T_MAX + 1);
    localparam int GAP_W  = BUSY_W + 1;

    typedef struct packed {
        logic              cmd_valid;
        logic [1:0]        cmd_kind;
        logic              cmd_orient;
        logic [BANK_W-1:0] cmd_bank;
        logic [SUB_W-1:0]  cmd_sub;
        logic [IDX_W-1:0]  cmd_idx;
        logic              cmd_write;
        logic [TAG_W-1:0]  cmd_tag;
        logic [BUSY_W-1:0] busy;
        logic              pend;
        logic [TAG_W-1:0]  pend_tag;
        logic              done_valid;
        logic [TAG_W-1:0]  done_tag;
        logic [GAP_W-1:0]  gap;
        logic [GAP_W-1:0]  last_t;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [DEPTH-1:0]             q_valid, q_orient, q_write;
    logic [DEPTH-1:0][BANK_W-1:0] q_bank;
    logic [DEPTH-1:0][SUB_W-1:0]  q_sub;
    logic [DEPTH-1:0][IDX_W-1:0]  q_idx;
    logic [DEPTH-1:0][TAG_W-1:0]  q_tag;
    logic                         q_full;
    logic [SA_N-1:0][1:0]         sa_st;
    logic [SA_N-1:0][IDX_W-1:0]   sa_ix;
    logic                         rw_found, act_found, act_pre;
    logic [SEL_W-1:0]             rw_sel, act_sel, sel;
    logic                         path_free, issue_rw, issue_act, issue;
    logic [ADDR_W-1:0]            tgt;
    logic                         push;
    logic [1:0]                   upd_state;
    logic                         older_same;

    assign req_ready = !q_full;
    assign push      = req_valid && !q_full;

    osched_queue #(
        .DEPTH(DEPTH), .BANK_W(BANK_W), .SUB_W(SUB_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_orient(req_orient), .push_bank(req_bank),
        .push_sub(req_sub), .push_idx(req_idx), .push_write(req_write),
        .push_tag(req_tag),
        .pop(issue_rw), .pop_sel(rw_sel),
        .q_valid(q_valid), .q_orient(q_orient), .q_bank(q_bank), .q_sub(q_sub),
        .q_idx(q_idx), .q_write(q_write), .q_tag(q_tag), .full(q_full)
    );

    osched_pick #(
        .DEPTH(DEPTH), .BANK_W(BANK_W), .SUB_W(SUB_W), .IDX_W(IDX_W)
    ) u_pick (
        .q_valid(q_valid), .q_orient(q_orient), .q_bank(q_bank), .q_sub(q_sub),
        .q_idx(q_idx), .sa_st(sa_st), .sa_ix(sa_ix),
        .rw_found(rw_found), .rw_sel(rw_sel),
        .act_found(act_found), .act_sel(act_sel), .act_pre(act_pre)
    );

    // Level two: the shared path is free in the last cycle of an occupancy;
    // a read/write candidate always wins over activation work.
    assign path_free = (c_q.busy <= BUSY_W'(1));
    assign issue_rw  = path_free && rw_found;
    assign issue_act = path_free && !rw_found && act_found;
    assign issue     = issue_rw || issue_act;
    assign sel       = issue_rw ? rw_sel : act_sel;
    assign tgt       = {q_bank[sel], q_sub[sel]};
    assign upd_state = act_pre ? SA_IDLE : (q_orient[sel] ? SA_COL : SA_ROW);

    osched_sa_table #(
        .SA_N(SA_N), .IDX_W(IDX_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .upd_en(issue_act), .upd_addr(tgt), .upd_state(upd_state),
        .upd_idx(q_idx[sel]),
        .sa_st(sa_st), .sa_ix(sa_ix)
    );

    always_comb begin
        c_d            = c_q;
        c_d.cmd_valid  = 1'b0;
        c_d.done_valid = 1'b0;
        if (c_q.busy != '0) begin
            c_d.busy = c_q.busy - BUSY_W'(1);
        end
        if (c_q.busy == BUSY_W'(1) && c_q.pend) begin
            c_d.done_valid = 1'b1;
            c_d.done_tag   = c_q.pend_tag;
            c_d.pend       = 1'b0;
        end
        if (c_q.gap != '1) begin
            c_d.gap = c_q.gap + GAP_W'(1);
        end
        if (issue) begin
            c_d.cmd_valid = 1'b1;
            c_d.cmd_bank  = q_bank[sel];
            c_d.cmd_sub   = q_sub[sel];
            c_d.cmd_write = q_write[sel];
            c_d.cmd_tag   = q_tag[sel];
            c_d.gap       = GAP_W'(1);
            if (issue_rw) begin
                c_d.cmd_kind   = CMD_RW;
                c_d.cmd_orient = q_orient[sel];
                c_d.cmd_idx    = q_idx[sel];
                c_d.busy       = BUSY_W'(T_RW);
                c_d.last_t     = GAP_W'(T_RW);
                c_d.pend       = 1'b1;
                c_d.pend_tag   = q_tag[sel];
            end else if (act_pre) begin
                c_d.cmd_kind   = CMD_PRE;
                c_d.cmd_orient = (sa_st[tgt] == SA_COL);
                c_d.cmd_idx    = sa_ix[tgt];
                c_d.busy       = BUSY_W'(T_PRE);
                c_d.last_t     = GAP_W'(T_PRE);
            end else begin
                c_d.cmd_kind   = CMD_ACT;
                c_d.cmd_orient = q_orient[sel];
                c_d.cmd_idx    = q_idx[sel];
                c_d.busy       = BUSY_W'(T_ACT);
                c_d.last_t     = GAP_W'(T_ACT);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q     <= '0;
            c_q.gap <= '1;
        end else begin
            c_q <= c_d;
        end
    end

    assign cmd_valid  = c_q.cmd_valid;
    assign cmd_kind   = c_q.cmd_kind;
    assign cmd_orient = c_q.cmd_orient;
    assign cmd_bank   = c_q.cmd_bank;
    assign cmd_sub    = c_q.cmd_sub;
    assign cmd_idx    = c_q.cmd_idx;
    assign cmd_write  = c_q.cmd_write;
    assign cmd_tag    = c_q.cmd_tag;
    assign done_valid = c_q.done_valid;
    assign done_tag   = c_q.done_tag;

    always_comb begin
        older_same = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(sel) && q_valid[i] && {q_bank[i], q_sub[i]} == tgt) begin
                older_same = 1'b1;
            end
        end
    end

    // R5: a read/write is granted only on the buffer it needs
    p_rw_hits_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_rw |-> (sa_st[tgt] == (q_orient[sel] ? SA_COL : SA_ROW))
                     && (sa_ix[tgt] == q_idx[sel]));

    // R7: nothing is issued past an older request to the same subarray
    p_same_sub_serial_r7: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !older_same);

    // R11: a new command waits out the occupancy of the previous one
    p_path_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (c_q.gap >= c_q.last_t));

    // R12: a completion always follows a pending read/write
    p_done_follows_rw_r12: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.done_valid |-> $past(c_q.pend));

endmodule

// File: tb/osched_top_bench.sv
module osched_top_bench;

    localparam int DEPTH = 16;
    localparam int T_PRE = 2;
    localparam int T_ACT = 3;
    localparam int T_RW  = 2;
    localparam int K_PRE = 1;
    localparam int K_ACT = 2;
    localparam int K_RW  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_orient = 1'b0;
    logic [1:0] req_bank = '0;
    logic [1:0] req_sub = '0;
    logic [3:0] req_idx = '0;
    logic       req_write = 1'b0;
    logic [3:0] req_tag = '0;
    logic       cmd_valid;
    logic [1:0] cmd_kind;
    logic       cmd_orient;
    logic [1:0] cmd_bank;
    logic [1:0] cmd_sub;
    logic [3:0] cmd_idx;
    logic       cmd_write;
    logic [3:0] cmd_tag;
    logic       done_valid;
    logic [3:0] done_tag;

    always #5 clk = ~clk;

    osched_top u_osched_top (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_orient(req_orient),
        .req_bank(req_bank), .req_sub(req_sub), .req_idx(req_idx),
        .req_write(req_write), .req_tag(req_tag),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_orient(cmd_orient),
        .cmd_bank(cmd_bank), .cmd_sub(cmd_sub), .cmd_idx(cmd_idx),
        .cmd_write(cmd_write), .cmd_tag(cmd_tag),
        .done_valid(done_valid), .done_tag(done_tag)
    );

    int n_checks = 0;
    int n_fail   = 0;

    int lg_kind [256];
    int lg_or   [256];
    int lg_bank [256];
    int lg_sub  [256];
    int lg_idx  [256];
    int lg_wr   [256];
    int lg_tag  [256];
    int lg_cyc  [256];
    int lg_n = 0;
    int dn_tag  [256];
    int dn_n = 0;

    int cyc = 0;
    int accepted = 0;
    int rw_seen = 0;
    int done_seen = 0;
    bit pend = 0;
    int pend_cyc = 0;
    int pend_tag = 0;
    int last_cyc = -100;
    int last_t = 0;
    bit chk_full = 0;
    bit saw_full = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n && req_valid && req_ready) accepted++;
    end

    // Monitor: logs commands and completions, checks path occupancy and done timing.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (done_valid) begin
                check(pend, "R12 done without read/write", 0, 1);
                check(cyc == pend_cyc + T_RW, "R12 done delay", cyc - pend_cyc, T_RW);
                check(int'(done_tag) == pend_tag, "R12 done tag", int'(done_tag), pend_tag);
                pend = 0;
                if (dn_n < 256) dn_tag[dn_n] = int'(done_tag);
                dn_n++;
                done_seen++;
            end else if (pend && cyc > pend_cyc + T_RW) begin
                check(0, "R12 done missing", cyc - pend_cyc, T_RW);
                pend = 0;
            end
            if (cmd_valid) begin
                check(cyc - last_cyc >= last_t, "R11 path gap", cyc - last_cyc, last_t);
                last_cyc = cyc;
                last_t = (cmd_kind == 2'd1) ? T_PRE : (cmd_kind == 2'd2) ? T_ACT : T_RW;
                if (lg_n < 256) begin
                    lg_kind[lg_n] = int'(cmd_kind);
                    lg_or[lg_n]   = int'(cmd_orient);
                    lg_bank[lg_n] = int'(cmd_bank);
                    lg_sub[lg_n]  = int'(cmd_sub);
                    lg_idx[lg_n]  = int'(cmd_idx);
                    lg_wr[lg_n]   = int'(cmd_write);
                    lg_tag[lg_n]  = int'(cmd_tag);
                    lg_cyc[lg_n]  = cyc;
                end
                lg_n++;
                if (cmd_kind == 2'd3) begin
                    rw_seen++;
                    pend = 1;
                    pend_cyc = cyc;
                    pend_tag = int'(cmd_tag);
                end
            end
            if (chk_full) begin
                check(req_ready == ((accepted - rw_seen) < DEPTH), "R2 ready vs held",
                      int'(req_ready), int'((accepted - rw_seen) < DEPTH));
                if (!req_ready) saw_full = 1;
            end
        end
    end

    task automatic push(input int o, input int b, input int s, input int ix,
                        input int w, input int t);
        req_valid  = 1'b1;
        req_orient = o[0];
        req_bank   = b[1:0];
        req_sub    = s[1:0];
        req_idx    = ix[3:0];
        req_write  = w[0];
        req_tag    = t[3:0];
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while ((accepted != done_seen) || pend) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_cmd(input int n, input int k, input int o, input int b,
                              input int s, input int ix, input string req);
        check(lg_kind[n] == k, {req, " kind"}, lg_kind[n], k);
        check(lg_or[n] == o && lg_bank[n] == b && lg_sub[n] == s && lg_idx[n] == ix,
              {req, " orient/bank/sub/idx"},
              lg_or[n] * 1000 + lg_bank[n] * 100 + lg_sub[n] * 10 + lg_idx[n],
              o * 1000 + b * 100 + s * 10 + ix);
    endtask

    task automatic t_reset();
        check(cmd_valid == 1'b0, "R1 cmd_valid after reset", int'(cmd_valid), 0);
        check(done_valid == 1'b0, "R1 done_valid after reset", int'(done_valid), 0);
        check(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);
    endtask

    task automatic t_idle_open();
        int b0;
        b0 = lg_n;
        push(0, 1, 2, 5, 1, 3);
        drain();
        check(lg_n - b0 == 2, "R4 command count", lg_n - b0, 2);
        expect_cmd(b0, K_ACT, 0, 1, 2, 5, "R4 activate");
        expect_cmd(b0 + 1, K_RW, 0, 1, 2, 5, "R4 read/write");
        check(lg_wr[b0 + 1] == 1 && lg_tag[b0 + 1] == 3, "R3 write/tag",
              lg_wr[b0 + 1] * 100 + lg_tag[b0 + 1], 103);
    endtask

    task automatic t_hit();
        int b0;
        b0 = lg_n;
        push(0, 1, 2, 5, 0, 4);
        drain();
        check(lg_n - b0 == 1, "R5 hit command count", lg_n - b0, 1);
        expect_cmd(b0, K_RW, 0, 1, 2, 5, "R5 hit read/write");
        check(lg_wr[b0] == 0 && lg_tag[b0] == 4, "R3 read/tag",
              lg_wr[b0] * 100 + lg_tag[b0], 4);
    endtask

    task automatic t_switch();
        int b0;
        b0 = lg_n;
        push(1, 1, 2, 5, 0, 6);
        drain();
        check(lg_n - b0 == 3, "R6 orientation switch count", lg_n - b0, 3);
        expect_cmd(b0, K_PRE, 0, 1, 2, 5, "R6 precharge row buffer");
        expect_cmd(b0 + 1, K_ACT, 1, 1, 2, 5, "R6 activate column");
        expect_cmd(b0 + 2, K_RW, 1, 1, 2, 5, "R6 column read/write");
        b0 = lg_n;
        push(1, 1, 2, 9, 1, 7);
        drain();
        check(lg_n - b0 == 3, "R6 index change count", lg_n - b0, 3);
        expect_cmd(b0, K_PRE, 1, 1, 2, 5, "R3 precharge carries closed buffer");
        expect_cmd(b0 + 1, K_ACT, 1, 1, 2, 9, "R6 activate new index");
        expect_cmd(b0 + 2, K_RW, 1, 1, 2, 9, "R6 read/write new index");
    endtask

    task automatic t_concurrent();
        int b0;
        push(0, 0, 0, 1, 0, 1);
        drain();
        push(1, 0, 1, 2, 0, 2);
        drain();
        b0 = lg_n;
        push(0, 0, 0, 1, 1, 3);
        drain();
        push(1, 0, 1, 2, 1, 4);
        drain();
        check(lg_n - b0 == 2, "R8 both buffers still open", lg_n - b0, 2);
        expect_cmd(b0, K_RW, 0, 0, 0, 1, "R8 row buffer of sub 0");
        expect_cmd(b0 + 1, K_RW, 1, 0, 1, 2, "R8 column buffer of sub 1");
    endtask

    task automatic t_order();
        int b0, d0;
        b0 = lg_n;
        d0 = dn_n;
        push(0, 3, 0, 1, 0, 1);
        push(1, 3, 0, 1, 1, 2);
        push(0, 3, 0, 1, 0, 3);
        drain();
        check(dn_n - d0 == 3, "R7 completions", dn_n - d0, 3);
        check(dn_tag[d0] == 1 && dn_tag[d0 + 1] == 2 && dn_tag[d0 + 2] == 3,
              "R7 arrival order", dn_tag[d0] * 100 + dn_tag[d0 + 1] * 10 + dn_tag[d0 + 2], 123);
        check(lg_n - b0 == 8, "R6 serialized switch count", lg_n - b0, 8);
        expect_cmd(b0 + 2, K_PRE, 0, 3, 0, 1, "R6 close row before column");
        expect_cmd(b0 + 3, K_ACT, 1, 3, 0, 1, "R6 open column");
        expect_cmd(b0 + 5, K_PRE, 1, 3, 0, 1, "R6 close column before row");
    endtask

    task automatic t_prio();
        int b0;
        b0 = lg_n;
        push(0, 2, 1, 4, 0, 5);
        push(1, 2, 0, 7, 0, 6);
        push(0, 2, 1, 4, 1, 7);
        drain();
        check(lg_n - b0 == 5, "R9 command count", lg_n - b0, 5);
        expect_cmd(b0, K_ACT, 0, 2, 1, 4, "R9 first activate");
        expect_cmd(b0 + 1, K_RW, 0, 2, 1, 4, "R9 first read/write");
        expect_cmd(b0 + 2, K_RW, 0, 2, 1, 4, "R9 younger hit before older activate");
        check(lg_tag[b0 + 2] == 7, "R9 granted tag", lg_tag[b0 + 2], 7);
        expect_cmd(b0 + 3, K_ACT, 1, 2, 0, 7, "R9 activate after read/write");
        expect_cmd(b0 + 4, K_RW, 1, 2, 0, 7, "R9 last read/write");
        check(lg_cyc[b0 + 1] - lg_cyc[b0] == T_ACT, "R11 gap after activate",
              lg_cyc[b0 + 1] - lg_cyc[b0], T_ACT);
        check(lg_cyc[b0 + 2] - lg_cyc[b0 + 1] == T_RW, "R11 gap after read/write",
              lg_cyc[b0 + 2] - lg_cyc[b0 + 1], T_RW);
    endtask

    task automatic t_age();
        int b0;
        b0 = lg_n;
        push(0, 1, 1, 0, 0, 8);
        push(0, 2, 2, 6, 0, 9);
        push(1, 1, 0, 3, 0, 10);
        drain();
        check(lg_n - b0 == 6, "R10 command count", lg_n - b0, 6);
        expect_cmd(b0 + 2, K_ACT, 0, 2, 2, 6, "R10 older activation first");
        expect_cmd(b0 + 4, K_ACT, 1, 1, 0, 3, "R10 younger activation last");
    endtask

    task automatic t_full();
        int d0;
        d0 = done_seen;
        chk_full = 1;
        for (int i = 0; i < 20; i++) begin
            push(i % 2, 0, 2, i % 3, 0, i % 16);
        end
        drain();
        chk_full = 0;
        check(saw_full, "R2 ready dropped when full", int'(saw_full), 1);
        check(done_seen - d0 == 20, "R2 no request lost", done_seen - d0, 20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_open();
        t_hit();
        t_switch();
        t_concurrent();
        t_order();
        t_prio();
        t_age();
        t_full();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule